// File: doc/BRIEF.md
# Audio Sample Concealment and Mute

This block sits between the demodulated stereo sample path and the audio output port. For each received frame, marked by a one-cycle valid strobe, it chooses one of three outputs for both channels. The live samples pass through on a clean frame. A short run of parity errors on PCM audio is covered by repeating the last clean stereo frame. A severe error, or a non-PCM stream while the non-PCM report mode is on, drives silence.

The block keeps the samples of the last error-free frame. It also keeps a copy of the non-PCM flag as it stood on that frame. During a parity-error run, this held flag decides between concealing and passing through, so a flag that is corrupted during the run cannot change the choice. Both outputs are registered and change only in the cycle after a strobe.

Top module: `audio_conceal`

## Requirements
- R1: While reset is high, and in the first cycle after it, both outputs are zero.
- R2: For a strobed frame with no parity error, with lock present and without a non-PCM mute, the live left and right samples appear on the outputs in the cycle after the strobe.
- R3: For a strobed frame with a parity error, a run count of 8 or less, lock present and the held flag showing PCM, both outputs carry the samples of the last error-free frame. After reset, the last error-free frame is zero.
- R4: The saved frame is replaced only by strobed frames without a parity error. Error frames leave it unchanged, including error frames that are passed through or muted.
- R5: For a strobed frame with a parity error, a run count of 8 or less and the held flag showing non-PCM, the live erroneous samples are output unchanged. This needs the non-PCM mute to be off, or no mute to be triggered.
- R6: During an error frame, the non-PCM flag that is used is the one captured on the last error-free frame. The live flag is ignored on error frames.
- R7: A strobed frame with lock low drives both outputs to zero.
- R8: A strobed frame with a parity error and a run count of 9 or more drives both outputs to zero.
- R9: When the non-PCM report mode is set and the effective non-PCM flag is high, both outputs are zero. The effective flag is the live flag on clean frames and the held flag on error frames.
- R10: Without a strobe, the outputs hold their value whatever the other inputs do.
- R11: Mute takes priority over concealment and over pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_left | input | 24 | Demodulated left sample |
| in_right | input | 24 | Demodulated right sample |
| frame_vld | input | 1 | One-cycle strobe per received frame |
| parity_err | input | 1 | Parity error on this frame |
| err_run | input | 4 | Consecutive parity-error count including this frame |
| lock_ok | input | 1 | Receiver locked |
| nonpcm | input | 1 | Stream flagged as non-PCM |
| nonpcm_mute_en | input | 1 | Non-PCM report mode: mute on non-PCM data |
| out_left | output | 24 | Processed left sample |
| out_right | output | 24 | Processed right sample |

## Verification
Concealment and mute can both be requested in the same frame. This happens when a parity error comes with lock loss, with a run count of 9 or more, or with a held non-PCM flag while report mode is on. The bench provokes each of these on purpose: it sets up a known saved frame first and then strikes the clash. It judges the result by requiring zero output rather than the saved samples, and then confirms through a later concealed frame that the saved frame was not disturbed. Random frames mix all the conditions as well, and a bench model that follows the stated priority predicts every one of them.

// File: rtl/conceal_pkg.sv
package conceal_pkg;
    parameter int SAMPLE_W = 24;

    typedef struct packed {
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } stereo_t;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_HOLD = 2'd1,
        SEL_ZERO = 2'd2
    } out_sel_e;

    function automatic out_sel_e pick_sel(
        input logic perr,
        input logic run_severe,
        input logic locked,
        input logic np_eff,
        input logic np_mute
    );
        if (!locked || (perr && run_severe) || (np_mute && np_eff))
            return SEL_ZERO;
        else if (perr && !np_eff)
            return SEL_HOLD;
        else
            return SEL_PASS;
    endfunction
endpackage

// File: rtl/conceal_history.sv
module conceal_history
    import conceal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_vld,
    input  logic    parity_err,
    input  stereo_t live,
    input  logic    nonpcm,
    output stereo_t last_good,
    output logic    np_held
);
    logic good_frame;
    assign good_frame = frame_vld && !parity_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_good <= '0;
            np_held   <= 1'b0;
        end else if (good_frame) begin
            last_good <= live;
            np_held   <= nonpcm;
        end
    end
endmodule

// File: rtl/conceal_decide.sv
module conceal_decide
    import conceal_pkg::*;
#(
    parameter int RUN_W    = 4,
    parameter int MUTE_RUN = 9
) (
    input  logic             parity_err,
    input  logic [RUN_W-1:0] err_run,
    input  logic             lock_ok,
    input  logic             nonpcm,
    input  logic             np_held,
    input  logic             nonpcm_mute_en,
    output out_sel_e         sel
);
    localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(MUTE_RUN);

    logic np_eff;
    logic run_severe;

    assign np_eff     = parity_err ? np_held : nonpcm;
    assign run_severe = (err_run >= RUN_LIMIT);

    always_comb begin
        sel = pick_sel(parity_err, run_severe, lock_ok, np_eff, nonpcm_mute_en);
    end
endmodule

// File: rtl/conceal_outreg.sv
module conceal_outreg
    import conceal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_vld,
    input  out_sel_e sel,
    input  stereo_t  live,
    input  stereo_t  last_good,
    output stereo_t  q
);
    stereo_t nxt;

    always_comb begin
        unique case (sel)
            SEL_PASS: nxt = live;
            SEL_HOLD: nxt = last_good;
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (frame_vld)
            q <= nxt;
    end
endmodule

// File: rtl/audio_conceal.sv
module audio_conceal
    import conceal_pkg::*;
#(
    parameter int RUN_W    = 4,
    parameter int MUTE_RUN = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                frame_vld,
    input  logic                parity_err,
    input  logic [RUN_W-1:0]    err_run,
    input  logic                lock_ok,
    input  logic                nonpcm,
    input  logic                nonpcm_mute_en,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    stereo_t  live;
    stereo_t  last_good;
    stereo_t  q;
    logic     np_held;
    out_sel_e sel;

    assign live.l = in_left;
    assign live.r = in_right;

    conceal_history u_hist (
        .clk        (clk),
        .rst        (rst),
        .frame_vld  (frame_vld),
        .parity_err (parity_err),
        .live       (live),
        .nonpcm     (nonpcm),
        .last_good  (last_good),
        .np_held    (np_held)
    );

    conceal_decide #(.RUN_W(RUN_W), .MUTE_RUN(MUTE_RUN)) u_dec (
        .parity_err     (parity_err),
        .err_run        (err_run),
        .lock_ok        (lock_ok),
        .nonpcm         (nonpcm),
        .np_held        (np_held),
        .nonpcm_mute_en (nonpcm_mute_en),
        .sel            (sel)
    );

    conceal_outreg u_out (
        .clk       (clk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .sel       (sel),
        .live      (live),
        .last_good (last_good),
        .q         (q)
    );

    assign out_left  = q.l;
    assign out_right = q.r;
endmodule

// File: rtl/audio_conceal_chk.sv
module audio_conceal_chk
    import conceal_pkg::*;
#(
    parameter int RUN_W    = 4,
    parameter int MUTE_RUN = 9
) (
    input logic                clk,
    input logic                rst,
    input logic [SAMPLE_W-1:0] in_left,
    input logic [SAMPLE_W-1:0] in_right,
    input logic                frame_vld,
    input logic                parity_err,
    input logic [RUN_W-1:0]    err_run,
    input logic                lock_ok,
    input logic                nonpcm,
    input logic                nonpcm_mute_en,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right
);
    localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(MUTE_RUN);

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (out_left == '0 && out_right == '0));

    p_clean_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !parity_err && lock_ok && !(nonpcm_mute_en && nonpcm))
        |=> (out_left == $past(in_left) && out_right == $past(in_right)));

    p_lock_mute_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !lock_ok) |=> (out_left == '0 && out_right == '0));

    p_run_mute_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && parity_err && err_run >= RUN_LIMIT)
        |=> (out_left == '0 && out_right == '0));

    p_np_mute_clean_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !parity_err && nonpcm_mute_en && nonpcm)
        |=> (out_left == '0 && out_right == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> ($stable(out_left) && $stable(out_right)));
endmodule

bind audio_conceal audio_conceal_chk #(.RUN_W(RUN_W), .MUTE_RUN(MUTE_RUN)) u_chk (.*);

// File: tb/audio_conceal_bench.sv
`timescale 1ns/1ps
module audio_conceal_bench;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] in_left, in_right;
    logic         frame_vld, parity_err, lock_ok, nonpcm, nonpcm_mute_en;
    logic [3:0]   err_run;
    logic [W-1:0] out_left, out_right;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] m_l, m_r, e_l, e_r;
    logic         m_np;

    always #10 clk = ~clk;

    audio_conceal u_audio_conceal (
        .clk(clk), .rst(rst), .in_left(in_left), .in_right(in_right),
        .frame_vld(frame_vld), .parity_err(parity_err), .err_run(err_run),
        .lock_ok(lock_ok), .nonpcm(nonpcm), .nonpcm_mute_en(nonpcm_mute_en),
        .out_left(out_left), .out_right(out_right)
    );

    task automatic check(input string tag, input logic [W-1:0] el, input logic [W-1:0] er);
        checks++;
        if (out_left !== el || out_right !== er) begin
            fails++;
            $display("FAIL %s: got L=%h R=%h expected L=%h R=%h", tag, out_left, out_right, el, er);
        end
    endtask

    // bench model: returns tag of the rule in force and sets e_l/e_r
    function automatic string model(input logic [W-1:0] l, input logic [W-1:0] r,
                                    input logic pe, input logic [3:0] run,
                                    input logic lk, input logic np, input logic npm);
        logic eff;
        string t;
        eff = pe ? m_np : np;
        if (!lk) begin e_l = '0; e_r = '0; t = "R7/R11"; end
        else if (pe && run >= 4'd9) begin e_l = '0; e_r = '0; t = "R8/R11"; end
        else if (npm && eff) begin e_l = '0; e_r = '0; t = "R9/R11"; end
        else if (pe && !eff) begin e_l = m_l; e_r = m_r; t = "R3/R4/R6"; end
        else if (pe) begin e_l = l; e_r = r; t = "R5/R6"; end
        else begin e_l = l; e_r = r; t = "R2"; end
        if (!pe) begin m_l = l; m_r = r; m_np = np; end
        return t;
    endfunction

    task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r,
                         input logic pe, input logic [3:0] run,
                         input logic lk, input logic np, input logic npm,
                         input string note);
        string t;
        in_left = l; in_right = r; parity_err = pe; err_run = run;
        lock_ok = lk; nonpcm = np; nonpcm_mute_en = npm; frame_vld = 1'b1;
        t = model(l, r, pe, run, lk, np, npm);
        @(posedge clk);
        @(negedge clk);
        frame_vld = 1'b0;
        check({t, " ", note}, e_l, e_r);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hl, hr;
        void'($urandom(32'd2024));
        m_l = '0; m_r = '0; m_np = 1'b0;
        rst = 1'b1; frame_vld = 0; parity_err = 0; err_run = 0;
        lock_ok = 1; nonpcm = 0; nonpcm_mute_en = 0;
        in_left = 24'h123456; in_right = 24'h654321;
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", '0, '0);

        // R3 right after reset: saved frame is zero
        frame(24'hAAAAAA, 24'h555555, 1, 1, 1, 0, 0, "conceal from reset");
        frame(24'h111111, 24'h222222, 0, 0, 1, 0, 0, "clean");
        for (int k = 1; k <= 8; k++)
            frame(24'h0F0F00 + W'(k), 24'hF0F000 + W'(k), 1, 4'(k), 1, 0, 0, "run up to 8");
        frame(24'h333333, 24'h444444, 1, 9, 1, 0, 0, "run 9 mutes");
        frame(24'h777777, 24'h888888, 1, 3, 1, 0, 0, "R4 saved kept after mute");
        frame(24'h999999, 24'hAAAAAA, 1, 3, 0, 0, 0, "lock lost during error");
        // R6: held PCM; live flag corrupt to non-PCM during run
        frame(24'hBBBBBB, 24'hCCCCCC, 1, 2, 1, 1, 1, "live np ignored");
        // held non-PCM passes erroneous data
        frame(24'h0A0B0C, 24'h0D0E0F, 0, 0, 1, 1, 0, "clean non-PCM");
        frame(24'hDEAD00, 24'hBEEF00, 1, 4, 1, 0, 0, "held non-PCM pass");
        frame(24'hDEAD01, 24'hBEEF01, 1, 4, 1, 0, 1, "held non-PCM mute");
        frame(24'hDEAD02, 24'hBEEF02, 0, 0, 1, 1, 1, "clean non-PCM mute");
        frame(24'h121212, 24'h343434, 0, 0, 0, 0, 0, "clean lock lost");
        frame(24'h565656, 24'h787878, 1, 1, 1, 0, 0, "R4 clean muted frame saved");

        // R10: no strobe, inputs wander
        hl = out_left; hr = out_right;
        for (int k = 0; k < 5; k++) begin
            in_left = W'($urandom); in_right = W'($urandom);
            parity_err = k[0]; lock_ok = k[1]; nonpcm = k[2];
            @(negedge clk);
            check("R10 hold without strobe", hl, hr);
        end

        for (int k = 0; k < 400; k++) begin
            logic pe, lk, np, npm;
            logic [3:0] run;
            pe  = ($urandom % 3) == 0;
            run = pe ? 4'(1 + $urandom % 11) : 4'd0;
            lk  = ($urandom % 10) != 0;
            np  = ($urandom % 4) == 0;
            npm = ($urandom % 3) == 0;
            frame(W'($urandom), W'($urandom), pe, run, lk, np, npm, "random");
            if ($urandom % 4 == 0) begin
                hl = out_left; hr = out_right;
                @(negedge clk);
                check("R10 random gap", hl, hr);
            end
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule